// File: doc/BRIEF.md
# Register-Programmed SPI Master Controller

This block is a SPI master that software drives through a small word-addressed register window. Software sets up a clock divider, a word length of one to eight bits, the clock idle level and the sampling edge. It then writes words into a 16-entry transmit queue. A shift engine sends each queued word out most-significant bit first. For every word sent, it clocks one word in from MISO and places it in a 16-entry receive queue, which software drains by reading the data register.

Chip select is a single pin. In software mode a control word drives it. In hardware mode the pin follows the busy flag. A parameter picks one of two meanings for the polarity and state bits of that control word. A run field in the reset register holds both queues empty and the shifter idle until software releases it. Only the run field (bits 1:0 equal to 3) and the offsets listed below affect behaviour. Other bits either read back unchanged or read as zero.

Top module: `spi_master_ctrl`

## Requirements
- R1: Once reset is released, the configuration registers read 0. The status register at 0x8 reads 0x4. SCLK is low. Chip select sits at its inactive level.
- R2: A write to the data register at 0x10 pushes bits 7:0 into the transmit queue. The level of that queue is reported in bits 21:16 of 0x44, from 0 to 16. A write to a full queue is dropped. Status bit 2 (transmit not full) is 0 when 16 words are queued.
- R3: While bits 1:0 of the reset register at 0x204 are not 3, both queues are held empty, data writes are discarded and no word is shifted.
- R4: The word length is bits 3:0 of 0x0 plus one, and values of 7 or more give 8 bits. Words go out MSB first. A received word is zero-extended into bits 7:0 of the data read.
- R5: One SCLK period is max(D+1, 2) clock cycles, where D is bits 19:8 of 0x0. When no word is shifting, SCLK rests at 0x4 bit 3 (the idle level).
- R6: MOSI changes only at bit boundaries. The input is sampled on the first SCLK edge of each bit when 0x4 bit 4 is 0, and on the second edge when it is 1. With MOSI looped back to MISO, every received word equals the word sent.
- R7: Every finished word pushes exactly one entry into the receive queue. The level of that queue is reported in bits 13:8 of 0x48. A read of 0x10 with the read strobe pops one entry. A read of an empty queue returns 0.
- R8: A word that finishes while the receive queue is full is dropped and sets status bit 7. That bit stays set until a write to 0x8 with bit 7 equal to 1. A write with bit 7 equal to 0 leaves it set.
- R9: Status bit 4 (busy) is 1 while a word is shifting, or while the transmit queue is non-empty and 0x0 bit 7 (enable) is set. Clearing enable lets the current word finish and then stops, leaving the remaining words queued.
- R10: The watermark fields (0x44 bits 13:8 and 5:0, 0x48 bits 5:0) store and read back what software writes, and they change no other behaviour.
- R11: Software mode is selected when bit 0 of 0x224 is 1. Bit 1 is the state bit and bit 12 is the polarity bit. In the first semantics the pin equals bit 1. In the second semantics the pin equals bit 12 when bit 1 is 1, and the inverse of bit 12 when bit 1 is 0.
- R12: Hardware mode is selected when bit 0 of 0x224 is 0. The pin is at the active level while busy and at the inverse level otherwise. The active level is bit 12 in the first semantics and the inverse of bit 12 in the second.
- R13: The following fields read back as written, with all other bits reading 0: in 0x0, bits 20, 19:8, 7 and 3:0; in 0x4, bits 16, 4 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; SCLK is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe; pops the receive queue when the data register is addressed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at bus_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_pin | output | 1 | Chip-select pin level |

## Verification
The bench sweeps every combination of clock idle level and sampling edge, four divider values (including 0, which must still give a two-cycle period) and four word lengths (including 1 bit and an out-of-range length field that must clamp to 8). A sampling edge off by half a period would capture the neighbouring bit on the loopback and show up as a wrong received word. A wrong length or a missing clamp would change the number of SCLK pulses the bench counts. It fills the receive queue and sends one more word. A design that overwrote the queue instead of dropping the word, or that cleared the overrun flag on a write of 0, would return the wrong sixteenth word or a wrong status. It also clears enable in the middle of a word. A design that aborted the word, or that kept draining the queue, would report the wrong queue levels afterwards. A second instance built with the other chip-select semantics checks that the polarity bit is inverted in both software and hardware modes.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [11:0] OFF_CTRL0 = 12'h000;
  localparam logic [11:0] OFF_CTRL1 = 12'h004;
  localparam logic [11:0] OFF_STAT  = 12'h008;
  localparam logic [11:0] OFF_DATA  = 12'h010;
  localparam logic [11:0] OFF_TXTH  = 12'h044;
  localparam logic [11:0] OFF_RXTH  = 12'h048;
  localparam logic [11:0] OFF_RUN   = 12'h204;
  localparam logic [11:0] OFF_CSCTL = 12'h224;

  localparam int STAT_TNF  = 2;
  localparam int STAT_RNE  = 3;
  localparam int STAT_BUSY = 4;
  localparam int STAT_ROR  = 7;

  localparam int WM_W = 6;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (cnt_q == LW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem_q[rp_q];
  assign level   = cnt_q;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = ptr_inc(wp_q);
      if (do_pop)  rp_d = ptr_inc(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + LW'(1);
        2'b01:   cnt_d = cnt_q - LW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= din;
  end
endmodule

// File: rtl/spim_shift_engine.sv
module spim_shift_engine #(
  parameter int W     = 8,
  parameter int DIV_W = 12,
  localparam int BW   = (W > 1) ? $clog2(W) : 1,
  localparam int CW   = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             enable,
  input  logic [DIV_W-1:0] div,
  input  logic [3:0]       dsz,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             tx_avail,
  input  logic [W-1:0]     tx_word,
  output logic             tx_take,
  input  logic             miso,
  output logic             rx_valid,
  output logic [W-1:0]     rx_word,
  output logic             active,
  output logic             sclk,
  output logic             mosi
);
  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d, per_q, per_d, half_q, half_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [W-1:0]  sh_q, sh_d, rx_q, rx_d;
  logic [CW-1:0] per_c, half_c;
  logic [BW-1:0] lenm1_c;
  logic          bit_last, word_end, sample_now;

  // Period in clock cycles, never shorter than two.
  assign per_c  = (div == '0) ? CW'(2) : CW'(div) + CW'(1);
  assign half_c = per_c >> 1;

  always_comb begin
    if (dsz >= 4'(W - 1)) lenm1_c = BW'(W - 1);
    else                  lenm1_c = BW'(dsz);
  end

  assign bit_last   = act_q && (cnt_q == per_q - CW'(1));
  assign word_end   = bit_last && (bit_q == '0);
  assign sample_now = act_q && (cnt_q == half_q - CW'(1));
  assign tx_take    = run && enable && tx_avail && (!act_q || word_end);
  assign rx_valid   = run && word_end;
  assign rx_word    = rx_q;
  assign active     = act_q;
  assign mosi       = act_q && sh_q[W-1];
  assign sclk       = cpol ^ (act_q && (cpha ? (cnt_q < half_q) : (cnt_q >= half_q)));

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    per_d  = per_q;
    half_d = half_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    if (!run) begin
      act_d = 1'b0;
      cnt_d = '0;
      bit_d = '0;
      sh_d  = '0;
      rx_d  = '0;
    end else begin
      if (sample_now) rx_d = {rx_q[W-2:0], miso};
      if (act_q) cnt_d = cnt_q + CW'(1);
      if (bit_last && (bit_q != '0)) begin
        cnt_d = '0;
        bit_d = bit_q - BW'(1);
        sh_d  = sh_q << 1;
      end
      if (word_end) act_d = 1'b0;
      if (tx_take) begin
        act_d  = 1'b1;
        cnt_d  = '0;
        per_d  = per_c;
        half_d = half_c;
        bit_d  = lenm1_c;
        sh_d   = tx_word << (BW'(W - 1) - lenm1_c);
        rx_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      per_q  <= CW'(2);
      half_q <= CW'(1);
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      half_q <= half_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
    end
  end
endmodule

// File: rtl/spim_cs_drive.sv
module spim_cs_drive #(
  parameter int VERSION = 1
) (
  input  logic sw_mode,
  input  logic state,
  input  logic pol,
  input  logic busy,
  output logic pin
);
  logic active_lvl, sw_lvl;

  generate
    if (VERSION == 2) begin : g_assert_sem
      assign active_lvl = ~pol;
      assign sw_lvl     = state ? pol : ~pol;
    end else begin : g_level_sem
      assign active_lvl = pol;
      assign sw_lvl     = state;
    end
  endgenerate

  assign pin = sw_mode ? sw_lvl : (busy ? active_lvl : ~active_lvl);
endmodule

// File: rtl/spi_master_ctrl.sv
module spi_master_ctrl #(
  parameter int ADDR_W     = 12,
  parameter int FIFO_DEPTH = 16,
  parameter int WORD_W     = 8,
  parameter int DIV_W      = 12,
  parameter int CS_VERSION = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_pin
);
  import spim_pkg::*;

  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  // Reset synchronizer: asynchronous assert, synchronous release.
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  // Address decode.
  logic hit_c0, hit_c1, hit_st, hit_dt, hit_tt, hit_rt, hit_rn, hit_cs;
  assign hit_c0 = (bus_addr == ADDR_W'(OFF_CTRL0));
  assign hit_c1 = (bus_addr == ADDR_W'(OFF_CTRL1));
  assign hit_st = (bus_addr == ADDR_W'(OFF_STAT));
  assign hit_dt = (bus_addr == ADDR_W'(OFF_DATA));
  assign hit_tt = (bus_addr == ADDR_W'(OFF_TXTH));
  assign hit_rt = (bus_addr == ADDR_W'(OFF_RXTH));
  assign hit_rn = (bus_addr == ADDR_W'(OFF_RUN));
  assign hit_cs = (bus_addr == ADDR_W'(OFF_CSCTL));

  // Configuration state.
  logic [DIV_W-1:0] div_q, div_d;
  logic             ext_q, ext_d, en_q, en_d;
  logic [3:0]       dsz_q, dsz_d;
  logic             cpol_q, cpol_d, cpha_q, cpha_d, frm_q, frm_d;
  logic [WM_W-1:0]  txlwm_q, txlwm_d, txhwm_q, txhwm_d, rxwm_q, rxwm_d;
  logic [2:0]       runc_q, runc_d;
  logic             cs_sw_q, cs_sw_d, cs_st_q, cs_st_d, cs_pol_q, cs_pol_d;
  logic             ror_q, ror_d;

  logic              run, busy, stat_clr;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [LVL_W-1:0]  tx_level, rx_level;
  logic [WORD_W-1:0] tx_head, rx_head, rx_word;
  logic              tx_take, rx_valid, eng_active;
  logic              unused_wdata_bits;

  assign run               = (runc_q[1:0] == 2'b11);
  assign stat_clr          = bus_wr && hit_st && bus_wdata[STAT_ROR];
  assign unused_wdata_bits = ^bus_wdata;

  always_comb begin
    div_d = div_q;  ext_d = ext_q;  en_d = en_q;  dsz_d = dsz_q;
    cpol_d = cpol_q; cpha_d = cpha_q; frm_d = frm_q;
    txlwm_d = txlwm_q; txhwm_d = txhwm_q; rxwm_d = rxwm_q;
    runc_d = runc_q;
    cs_sw_d = cs_sw_q; cs_st_d = cs_st_q; cs_pol_d = cs_pol_q;
    if (bus_wr) begin
      if (hit_c0) begin
        div_d = bus_wdata[8 +: DIV_W];
        ext_d = bus_wdata[20];
        en_d  = bus_wdata[7];
        dsz_d = bus_wdata[3:0];
      end
      if (hit_c1) begin
        cpol_d = bus_wdata[3];
        cpha_d = bus_wdata[4];
        frm_d  = bus_wdata[16];
      end
      if (hit_tt) begin
        txlwm_d = bus_wdata[8 +: WM_W];
        txhwm_d = bus_wdata[0 +: WM_W];
      end
      if (hit_rt) rxwm_d = bus_wdata[0 +: WM_W];
      if (hit_rn) runc_d = bus_wdata[2:0];
      if (hit_cs) begin
        cs_sw_d  = bus_wdata[0];
        cs_st_d  = bus_wdata[1];
        cs_pol_d = bus_wdata[12];
      end
    end
    // Sticky overrun: setting wins over a same-cycle clear.
    ror_d = (ror_q && !stat_clr) || (rx_valid && rx_full);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      div_q <= '0; ext_q <= 1'b0; en_q <= 1'b0; dsz_q <= '0;
      cpol_q <= 1'b0; cpha_q <= 1'b0; frm_q <= 1'b0;
      txlwm_q <= '0; txhwm_q <= '0; rxwm_q <= '0;
      runc_q <= '0;
      cs_sw_q <= 1'b0; cs_st_q <= 1'b0; cs_pol_q <= 1'b0;
      ror_q <= 1'b0;
    end else begin
      div_q <= div_d; ext_q <= ext_d; en_q <= en_d; dsz_q <= dsz_d;
      cpol_q <= cpol_d; cpha_q <= cpha_d; frm_q <= frm_d;
      txlwm_q <= txlwm_d; txhwm_q <= txhwm_d; rxwm_q <= rxwm_d;
      runc_q <= runc_d;
      cs_sw_q <= cs_sw_d; cs_st_q <= cs_st_d; cs_pol_q <= cs_pol_d;
      ror_q <= ror_d;
    end
  end

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_i_n), .flush(!run),
    .push(bus_wr && hit_dt && run), .din(bus_wdata[WORD_W-1:0]),
    .pop(tx_take), .dout(tx_head),
    .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  spim_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_i_n), .flush(!run),
    .push(rx_valid), .din(rx_word),
    .pop(bus_rd && hit_dt && run), .dout(rx_head),
    .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  spim_shift_engine #(.W(WORD_W), .DIV_W(DIV_W)) engine_i (
    .clk(clk), .rst_n(rst_i_n), .run(run), .enable(en_q),
    .div(div_q), .dsz(dsz_q), .cpol(cpol_q), .cpha(cpha_q),
    .tx_avail(!tx_empty), .tx_word(tx_head), .tx_take(tx_take),
    .miso(miso), .rx_valid(rx_valid), .rx_word(rx_word),
    .active(eng_active), .sclk(sclk), .mosi(mosi)
  );

  assign busy = eng_active || (!tx_empty && en_q);

  spim_cs_drive #(.VERSION(CS_VERSION)) cs_i (
    .sw_mode(cs_sw_q), .state(cs_st_q), .pol(cs_pol_q),
    .busy(busy), .pin(cs_pin)
  );

  // Read mux.
  always_comb begin
    bus_rdata = '0;
    if (hit_c0) begin
      bus_rdata[8 +: DIV_W] = div_q;
      bus_rdata[20]         = ext_q;
      bus_rdata[7]          = en_q;
      bus_rdata[3:0]        = dsz_q;
    end else if (hit_c1) begin
      bus_rdata[3]  = cpol_q;
      bus_rdata[4]  = cpha_q;
      bus_rdata[16] = frm_q;
    end else if (hit_st) begin
      bus_rdata[STAT_TNF]  = !tx_full;
      bus_rdata[STAT_RNE]  = !rx_empty;
      bus_rdata[STAT_BUSY] = busy;
      bus_rdata[STAT_ROR]  = ror_q;
    end else if (hit_dt) begin
      if (!rx_empty) bus_rdata[WORD_W-1:0] = rx_head;
    end else if (hit_tt) begin
      bus_rdata[16 +: WM_W] = WM_W'(tx_level);
      bus_rdata[8 +: WM_W]  = txlwm_q;
      bus_rdata[0 +: WM_W]  = txhwm_q;
    end else if (hit_rt) begin
      bus_rdata[8 +: WM_W]  = WM_W'(rx_level);
      bus_rdata[0 +: WM_W]  = rxwm_q;
    end else if (hit_rn) begin
      bus_rdata[2:0] = runc_q;
    end else if (hit_cs) begin
      bus_rdata[0]  = cs_sw_q;
      bus_rdata[1]  = cs_st_q;
      bus_rdata[12] = cs_pol_q;
    end
  end
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int DEPTH   = 16,
  parameter int VERSION = 1,
  parameter int LVL_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             eng_active,
  input logic             sclk,
  input logic             cpol,
  input logic [LVL_W-1:0] tx_level,
  input logic [LVL_W-1:0] rx_level,
  input logic             ror,
  input logic             stat_clr,
  input logic             rx_push,
  input logic             rx_full,
  input logic             cs_sw,
  input logic             cs_state,
  input logic             cs_pol,
  input logic             cs_pin,
  input logic             busy
);
  // R2: queue levels never exceed the depth
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LVL_W'(DEPTH)) && (rx_level <= LVL_W'(DEPTH)));

  // R3: leaving run low empties both queues and idles the shifter
  a_r3_held_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (tx_level == '0) && (rx_level == '0) && !eng_active);

  // R5: SCLK rests at the idle level whenever no word is shifting
  a_r5_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_active |-> (sclk == cpol));

  // R7: the receive level grows by at most one entry per cycle
  a_r7_rx_step: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= $past(rx_level) + LVL_W'(1));

  // R8: an overflowing push sets the flag
  a_r8_ror_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_full |=> ror);

  // R8: the flag holds until a write-one clear
  a_r8_ror_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ror && !stat_clr |=> ror);

  // R11: software-mode pin level
  a_r11_cs_sw: assert property (@(posedge clk) disable iff (!rst_n)
    cs_sw |-> (cs_pin == ((VERSION == 2) ? (cs_state ? cs_pol : !cs_pol) : cs_state)));

  // R12: hardware-mode pin follows busy
  a_r12_cs_hw: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_sw |-> (cs_pin == (((VERSION == 2) ? !cs_pol : cs_pol) ~^ busy)));
endmodule

bind spi_master_ctrl spim_checker #(
  .DEPTH(FIFO_DEPTH), .VERSION(CS_VERSION), .LVL_W(LVL_W)
) chk_i (
  .clk(clk), .rst_n(rst_i_n), .run(run), .eng_active(eng_active),
  .sclk(sclk), .cpol(cpol_q), .tx_level(tx_level), .rx_level(rx_level),
  .ror(ror_q), .stat_clr(stat_clr), .rx_push(rx_valid), .rx_full(rx_full),
  .cs_sw(cs_sw_q), .cs_state(cs_st_q), .cs_pol(cs_pol_q),
  .cs_pin(cs_pin), .busy(busy)
);

// File: tb/spi_master_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_master_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata, rdata_b;
  logic        sclk, mosi, miso, cs_pin;
  logic        sclk_b, mosi_b, cs_pin_b;
  logic        miso_force;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign miso = miso_force ? 1'b1 : mosi;

  spi_master_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_pin(cs_pin));

  spi_master_ctrl #(.CS_VERSION(2)) dut_v2_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
    .sclk(sclk_b), .mosi(mosi_b), .miso(miso), .cs_pin(cs_pin_b));

  // SCLK monitor: captures MOSI on the sampling edge, times leading edges.
  logic       mon_cpol, mon_cpha, prev_sclk;
  int         cyc = 0;
  int         mon_bits, lead_n, t0, t1;
  logic [15:0] mon_word;

  always @(negedge clk) begin
    cyc++;
    if (sclk !== prev_sclk) begin
      if ((sclk != mon_cpol) == !mon_cpha) begin
        mon_word = {mon_word[14:0], mosi};
        mon_bits++;
      end
      if (sclk != mon_cpol) begin
        if (lead_n == 0) t0 = cyc;
        if (lead_n == 1) t1 = cyc;
        lead_n++;
      end
    end
    prev_sclk = sclk;
  end

  task automatic mon_clear();
    mon_word = '0; mon_bits = 0; lead_n = 0; t0 = 0; t1 = 0;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pop(output logic [31:0] d);
    @(negedge clk);
    bus_addr = 12'h010; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(12'h008, s);
      if (!s[4]) break;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; miso_force = 1'b0;
    mon_cpol = 1'b0; mon_cpha = 1'b0; prev_sclk = 1'b0;
    mon_clear();
    settle(5);
    rst_n = 1'b1;
    settle(4);

    // R1: reset state
    rd(12'h008, v); chk("R1 status", v, 32'h4);
    rd(12'h000, v); chk("R1 ctrl0", v, 32'h0);
    rd(12'h224, v); chk("R1 csctl", v, 32'h0);
    chk("R1 sclk", {31'b0, sclk}, 32'h0);
    chk("R1 cs v1 idle", {31'b0, cs_pin}, 32'h1);
    chk("R1 cs v2 idle", {31'b0, cs_pin_b}, 32'h0);

    // R3: writes discarded while held
    wr(12'h010, 32'h5A);
    rd(12'h044, v); chk("R3 held tx level", v, 32'h0);

    // R2: fill with enable clear, 17th write dropped
    wr(12'h204, 32'h3);
    wr(12'h000, 32'h7);
    for (int k = 0; k < 17; k++) wr(12'h010, 32'(k));
    rd(12'h044, v); chk("R2 tx level full", v, 32'h10 << 16);
    rd(12'h008, v); chk("R2 tnf low", v & 32'h4, 32'h0);
    // R3: dropping run flushes the queue
    wr(12'h204, 32'h0);
    wr(12'h204, 32'h3);
    rd(12'h044, v); chk("R3 flushed", v, 32'h0);

    // R4 R5 R6 R7: mode / divider / length sweep with loopback
    n = 0;
    for (int cp = 0; cp < 2; cp++)
      for (int ph = 0; ph < 2; ph++)
        for (int di = 0; di < 4; di++)
          for (int si = 0; si < 4; si++) begin
            int div, dsz, len, per;
            logic [7:0] b, e;
            div = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 2 : 5;
            dsz = (si == 0) ? 7 : (si == 1) ? 3 : (si == 2) ? 0 : 12;
            len = (dsz >= 7) ? 8 : dsz + 1;
            per = (div == 0) ? 2 : div + 1;
            b = 8'((n * 37 + 11) & 255);
            e = b & 8'((1 << len) - 1);
            n++;
            wr(12'h004, 32'((cp << 3) | (ph << 4)));
            mon_cpol = cp[0]; mon_cpha = ph[0];
            wr(12'h000, 32'((div << 8) | 32'h80 | dsz));
            settle(1);
            mon_clear();
            wr(12'h010, 32'(b));
            wait_idle();
            chk("R4 bit count", 32'(mon_bits), 32'(len));
            chk("R6 mosi word", 32'(mon_word), 32'(e));
            if (len >= 2) chk("R5 period", 32'(t1 - t0), 32'(per));
            chk("R5 idle level", {31'b0, sclk}, 32'(cp));
            pop(v); chk("R7 loopback rx", v, 32'(e));
          end

    // R4: zero extension of a short received word
    wr(12'h004, 32'h0); mon_cpol = 1'b0; mon_cpha = 1'b0;
    wr(12'h000, 32'h83);
    miso_force = 1'b1;
    wr(12'h010, 32'h00);
    wait_idle();
    miso_force = 1'b0;
    pop(v); chk("R4 zero extend", v, 32'h0F);

    // R8: overrun drops the 17th word, sticky until write-one
    wr(12'h000, 32'h7);
    for (int k = 0; k < 16; k++) wr(12'h010, 32'(k * 3 + 1));
    wr(12'h000, 32'h87);
    wait_idle();
    rd(12'h048, v); chk("R7 rx level 16", v, 32'h10 << 8);
    wr(12'h010, 32'hEE);
    wait_idle();
    rd(12'h008, v); chk("R8 ror set", v & 32'h80, 32'h80);
    rd(12'h048, v); chk("R8 rx level stays", v, 32'h10 << 8);
    wr(12'h008, 32'h0);
    rd(12'h008, v); chk("R8 ror kept on zero write", v & 32'h80, 32'h80);
    wr(12'h008, 32'h80);
    rd(12'h008, v); chk("R8 ror cleared", v & 32'h80, 32'h0);
    for (int k = 0; k < 16; k++) begin
      pop(v); chk("R8 kept word", v, 32'(k * 3 + 1));
    end
    pop(v); chk("R7 empty read", v, 32'h0);

    // R9 R12: enable cleared mid-word; hardware chip select
    wr(12'h000, 32'h987);
    wr(12'h010, 32'hA1); wr(12'h010, 32'hB2); wr(12'h010, 32'hC3);
    settle(10);
    rd(12'h008, v); chk("R9 busy while shifting", v & 32'h10, 32'h10);
    chk("R12 v1 active low", {31'b0, cs_pin}, 32'h0);
    chk("R12 v2 active high", {31'b0, cs_pin_b}, 32'h1);
    wr(12'h000, 32'h907);
    wait_idle();
    rd(12'h048, v); chk("R9 one word done", v, 32'h1 << 8);
    rd(12'h044, v); chk("R9 two words left", v, 32'h2 << 16);
    chk("R9 sclk idle", {31'b0, sclk}, 32'h0);
    chk("R12 v1 inactive", {31'b0, cs_pin}, 32'h1);
    chk("R12 v2 inactive", {31'b0, cs_pin_b}, 32'h0);
    wr(12'h000, 32'h987);
    wait_idle();
    rd(12'h048, v); chk("R9 resumed", v, 32'h3 << 8);
    pop(v); chk("R9 word a", v, 32'hA1);
    pop(v); chk("R9 word b", v, 32'hB2);
    pop(v); chk("R9 word c", v, 32'hC3);

    // R10: watermark storage
    wr(12'h044, 32'h0000_0A05);
    rd(12'h044, v); chk("R10 tx marks", v, 32'h0A05);
    wr(12'h044, 32'hFFFF_FFFF);
    rd(12'h044, v); chk("R10 tx marks masked", v, 32'h3F3F);
    wr(12'h048, 32'hFFFF_FFFF);
    rd(12'h048, v); chk("R10 rx mark", v, 32'h3F);

    // R11: software chip select, both semantics
    for (int p = 0; p < 2; p++)
      for (int s = 0; s < 2; s++) begin
        wr(12'h224, 32'(1 | (s << 1) | (p << 12)));
        settle(1);
        chk("R11 v1 pin", {31'b0, cs_pin}, 32'(s));
        chk("R11 v2 pin", {31'b0, cs_pin_b}, (s != 0) ? 32'(p) : 32'(1 - p));
        rd(12'h224, v); chk("R11 readback", v, 32'(1 | (s << 1) | (p << 12)));
      end
    // R12: hardware mode with polarity 1, idle
    wr(12'h224, 32'h1000);
    settle(1);
    chk("R12 v1 idle pol1", {31'b0, cs_pin}, 32'h0);
    chk("R12 v2 idle pol1", {31'b0, cs_pin_b}, 32'h1);

    // R13: control register readback
    wr(12'h000, 32'hFFFF_FF7F);
    rd(12'h000, v); chk("R13 ctrl0", v, 32'h001F_FF0F);
    wr(12'h004, 32'hFFFF_FFFF);
    rd(12'h004, v); chk("R13 ctrl1", v, 32'h0001_0018);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule